// File: doc/BRIEF.md
# Timed-Trigger Decimating Sample Synchronizer

This block lets several identical receive units that share one reference clock produce samples at exactly the same instants and with the same oscillator phase. Each unit keeps a 64-bit sample-clock timestamp counter. A raw pulse-per-second input is brought into the clock domain and, on its rising edge, loads a value that software set beforehand. Every unit that loads the same value on the same pulse then has the same notion of time.

Software programs a start time. When the timestamp reaches it, the block restarts its decimation counter and clears its phase accumulator. It also applies a new decimation ratio and frequency tuning word, which were staged earlier and do not act before that moment. From then on the block emits one strobe every `ratio` cycles. Each strobe carries the timestamp of its sampling instant, so samples from different units can be matched by tag.

A gap register records how many clock cycles pass between a timestamp load and the next strobe. This allows alignment when the timed restart is not used. The sample datapath is modelled only as picking one cycle in `ratio`.

Top module: `tts_sample_sync`

## Requirements
- R1: While reset is held: `ts_now` is 0, `smp_vld` is 0, `armed` and `late` are 0, `nco_phase` is 0 and `trig_gap` is 0.
- R2: `pps_in` goes high and is first sampled high at clock edge k. At edge k+2 the counter loads the pending value P plus the synchronizer latency of 2, so `ts_now` reads P+2 after edge k+2. A level that stays high loads only once.
- R3: Outside a load, `ts_now` increases by exactly 1 on every clock edge.
- R4: A `start_wr` whose `start_val` is greater than the current `ts_now` sets `armed`. The block fires once, at the edge where `ts_now` equals `start_val`, and `armed` then clears.
- R5: A `start_wr` whose `start_val` is less than or equal to the current `ts_now` sets `late`, leaves `armed` low and never fires. The active ratio and tuning word are unchanged.
- R6: No strobe appears before the first start. The start event emits a strobe tagged with the start time S. Further strobes carry the tags S+n·D, where D is the active ratio.
- R7: `nco_phase` is 0 in the cycle after the start edge. It then advances by the active tuning word F on every edge, modulo 2^32, so it reads D·F when the strobe tagged S+D is visible.
- R8: A value written with `cfg_wr` is only staged. The active ratio and tuning word change only at a start event.
- R9: After a timestamp load, `trig_gap` reports N, the number of edges from the load edge to the edge that registers the next strobe. N equals that strobe's tag minus the timestamp after the load, plus 1.
- R10: A ratio of 2000 is supported. The strobes tagged S and S+2000 are 2000 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | Raw pulse-per-second level, synchronous to the reference |
| ptime_wr | input | 1 | Write strobe for the pending load value |
| ptime_val | input | 64 | Pending timestamp to load on the next pulse |
| start_wr | input | 1 | Write strobe that arms the start compare |
| start_val | input | 64 | Start time |
| cfg_wr | input | 1 | Write strobe for staged ratio and tuning word |
| cfg_ratio | input | 16 | Staged decimation ratio |
| cfg_ftw | input | 32 | Staged frequency tuning word |
| ts_now | output | 64 | Current timestamp |
| armed | output | 1 | Start compare waiting |
| late | output | 1 | Last start time was already past |
| smp_vld | output | 1 | Decimated sample strobe |
| smp_ts | output | 64 | Timestamp tag of the strobe |
| nco_phase | output | 32 | Phase accumulator |
| trig_gap | output | 17 | Cycles from last load to next strobe |

## Verification
The hardest situation to create is a timestamp load that lands while decimation is already running at a known phase. The gap can only be predicted from tags that the bench itself reads. The stimulus first starts decimation with a short ratio and then raises the pulse. It takes the post-load timestamp and the tag of the next strobe from the ports, and derives the expected gap from those two values. A second case that is hard to reach is a rejected start with a different configuration staged. The bench stages a new ratio, sends a start time already in the past, and confirms that the old strobe spacing continues.

// File: rtl/tts_pkg.sv
package tts_pkg;
   typedef enum logic [1:0] {
      CMP_IDLE  = 2'd0,
      CMP_ARMED = 2'd1,
      CMP_LATE  = 2'd2,
      CMP_DONE  = 2'd3
   } cmp_state_t;
endpackage

// File: rtl/tts_pps_sync.sv
module tts_pps_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pps_in,
   output logic ld_pulse
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   initial assert (STAGES >= 2) else $error("synchronizer needs two stages");

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= pps_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];

   assign ld_pulse = chain[STAGES-1] & ~last_q;

   // R2: one load per rising edge of the pulse input
   p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_pulse |=> !ld_pulse);
endmodule

// File: rtl/tts_timebase.sv
module tts_timebase
   import tts_pkg::*;
#(
   parameter int TS_W = 64,
   parameter int LAT  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_pulse,
   input  logic            ptime_wr,
   input  logic [TS_W-1:0] ptime_val,
   input  logic            start_wr,
   input  logic [TS_W-1:0] start_val,
   output logic [TS_W-1:0] ts,
   output logic            fire,
   output logic            armed,
   output logic            late
);
   logic [TS_W-1:0] pend_q;
   logic [TS_W-1:0] tgt_q;
   cmp_state_t      st_q;

   initial assert (TS_W >= 32) else $error("timestamp too narrow");

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        pend_q <= '0;
      else if (ptime_wr) pend_q <= ptime_val;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        ts <= '0;
      else if (ld_pulse) ts <= pend_q + TS_W'(LAT);
      else               ts <= ts + 1'b1;

   assign fire  = (st_q == CMP_ARMED) && (ts == tgt_q);
   assign armed = (st_q == CMP_ARMED);
   assign late  = (st_q == CMP_LATE);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st_q  <= CMP_IDLE;
         tgt_q <= '0;
      end else if (start_wr) begin
         tgt_q <= start_val;
         st_q  <= (start_val <= ts) ? CMP_LATE : CMP_ARMED;
      end else if (fire) begin
         st_q  <= CMP_DONE;
      end

   // R3: counter steps by one outside a load
   p_ts_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_pulse |=> ts == $past(ts) + 1'b1);
   // R4: the compare fires once and disarms
   p_fire_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !start_wr |=> !armed && !fire);
   // R5: a start time already passed is flagged and not armed
   p_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr && (start_val <= ts) |=> late && !armed);
endmodule

// File: rtl/tts_nco.sv
module tts_nco #(
   parameter int PH_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic            cfg_wr,
   input  logic [PH_W-1:0] cfg_ftw,
   output logic [PH_W-1:0] phase
);
   logic [PH_W-1:0] ftw_sh;
   logic [PH_W-1:0] ftw_act;

   initial assert (PH_W >= 8) else $error("phase width too small");

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      ftw_sh <= '0;
      else if (cfg_wr) ftw_sh <= cfg_ftw;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ftw_act <= '0;
         phase   <= '0;
      end else if (fire) begin
         ftw_act <= ftw_sh;
         phase   <= '0;
      end else begin
         phase   <= phase + ftw_act;
      end

   // R7: accumulator starts from zero after the timed start
   p_phase_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> phase == '0);
   // R8: tuning word changes only at a start
   p_ftw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(ftw_act));
endmodule

// File: rtl/tts_decim.sv
module tts_decim #(
   parameter int DEC_W = 16,
   parameter int TS_W  = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic            ld_pulse,
   input  logic            cfg_wr,
   input  logic [DEC_W-1:0] cfg_ratio,
   input  logic [TS_W-1:0] ts,
   output logic            smp_vld,
   output logic [TS_W-1:0] smp_ts,
   output logic [DEC_W:0]  gap
);
   localparam int GAP_W = DEC_W + 1;

   logic [DEC_W-1:0] ratio_sh, ratio_act, cnt, last;
   logic             started, hit, run;
   logic [GAP_W-1:0] gcnt, gnext;

   initial assert (DEC_W >= 11) else $error("ratio field cannot hold 2000");

   assign last  = (ratio_act == '0) ? '0 : ratio_act - 1'b1;
   assign hit   = fire | (started & (cnt == last));
   assign gnext = (&gcnt) ? gcnt : gcnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      ratio_sh <= DEC_W'(1);
      else if (cfg_wr) ratio_sh <= cfg_ratio;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ratio_act <= DEC_W'(1);
         cnt       <= '0;
         started   <= 1'b0;
      end else if (fire) begin
         ratio_act <= ratio_sh;
         cnt       <= '0;
         started   <= 1'b1;
      end else if (started) begin
         cnt       <= (cnt == last) ? '0 : cnt + 1'b1;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         smp_vld <= 1'b0;
         smp_ts  <= '0;
      end else begin
         smp_vld <= hit;
         if (hit) smp_ts <= ts;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         run  <= 1'b0;
         gcnt <= '0;
         gap  <= '0;
      end else if (ld_pulse) begin
         run  <= 1'b1;
         gcnt <= '0;
      end else if (run) begin
         if (hit) begin
            gap <= gnext;
            run <= 1'b0;
         end else begin
            gcnt <= gnext;
         end
      end

   // R6: the start edge emits a strobe tagged with the start time
   p_strobe_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> smp_vld && smp_ts == $past(ts) && cnt == '0);
   // R8: ratio changes only at a start
   p_ratio_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(ratio_act));
endmodule

// File: rtl/tts_sample_sync.sv
module tts_sample_sync #(
   parameter int TS_W        = 64,
   parameter int DEC_W       = 16,
   parameter int PH_W        = 32,
   parameter int OUT_PH_W    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pps_in,
   input  logic                ptime_wr,
   input  logic [TS_W-1:0]     ptime_val,
   input  logic                start_wr,
   input  logic [TS_W-1:0]     start_val,
   input  logic                cfg_wr,
   input  logic [DEC_W-1:0]    cfg_ratio,
   input  logic [PH_W-1:0]     cfg_ftw,
   output logic [TS_W-1:0]     ts_now,
   output logic                armed,
   output logic                late,
   output logic                smp_vld,
   output logic [TS_W-1:0]     smp_ts,
   output logic [OUT_PH_W-1:0] nco_phase,
   output logic [DEC_W:0]      trig_gap
);
   localparam int LAT = SYNC_STAGES;

   logic            ld_pulse, fire;
   logic [PH_W-1:0] phase_full;

   initial assert (OUT_PH_W <= PH_W && OUT_PH_W > 0) else $error("bad phase output width");

   tts_pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .ld_pulse(ld_pulse));

   tts_timebase #(.TS_W(TS_W), .LAT(LAT)) u_tb (
      .clk(clk), .rst_n(rst_n), .ld_pulse(ld_pulse),
      .ptime_wr(ptime_wr), .ptime_val(ptime_val),
      .start_wr(start_wr), .start_val(start_val),
      .ts(ts_now), .fire(fire), .armed(armed), .late(late));

   tts_nco #(.PH_W(PH_W)) u_nco (
      .clk(clk), .rst_n(rst_n), .fire(fire),
      .cfg_wr(cfg_wr), .cfg_ftw(cfg_ftw), .phase(phase_full));

   tts_decim #(.DEC_W(DEC_W), .TS_W(TS_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .fire(fire), .ld_pulse(ld_pulse),
      .cfg_wr(cfg_wr), .cfg_ratio(cfg_ratio), .ts(ts_now),
      .smp_vld(smp_vld), .smp_ts(smp_ts), .gap(trig_gap));

   if (OUT_PH_W == PH_W) begin : g_phase_full
      assign nco_phase = phase_full;
   end else begin : g_phase_trunc
      assign nco_phase = phase_full[PH_W-1 -: OUT_PH_W];
   end
endmodule

// File: tb/sim_tts_sample_sync.sv
module sim_tts_sample_sync;
   typedef struct packed {
      logic [15:0] d;
      logic [31:0] f;
      logic [15:0] lead;
   } vec_t;

   localparam int NV = 4;
   localparam vec_t VEC [NV] = '{
      '{16'd1,    32'h1000_0000, 16'd5},
      '{16'd3,    32'h0123_4567, 16'd9},
      '{16'd7,    32'hFFFF_FFFF, 16'd4},
      '{16'd2000, 32'h0010_0000, 16'd20}
   };

   logic        clk = 0, rst_n = 0, pps_in = 0;
   logic        ptime_wr = 0, start_wr = 0, cfg_wr = 0;
   logic [63:0] ptime_val = 0, start_val = 0;
   logic [15:0] cfg_ratio = 0;
   logic [31:0] cfg_ftw = 0;
   logic [63:0] ts_now, smp_ts;
   logic        armed, late, smp_vld;
   logic [31:0] nco_phase;
   logic [16:0] trig_gap;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tts_sample_sync u0 (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_cfg(input logic [15:0] d, input logic [31:0] f);
      @(negedge clk); cfg_wr = 1; cfg_ratio = d; cfg_ftw = f;
      @(negedge clk); cfg_wr = 0;
   endtask

   task automatic arm(input logic [15:0] lead, output logic [63:0] s);
      @(negedge clk);
      s = ts_now + 64'(lead);
      start_val = s; start_wr = 1;
      @(negedge clk); start_wr = 0;
      chk("R4 armed after future start", 64'(armed), 64'd1);
      chk("R5 late clear after future start", 64'(late), 64'd0);
   endtask

   task automatic pps_load(input logic [63:0] p, output logic [63:0] after);
      @(negedge clk); ptime_wr = 1; ptime_val = p;
      @(negedge clk); ptime_wr = 0; pps_in = 1;
      @(posedge clk); @(posedge clk); @(posedge clk);
      @(negedge clk);
      after = ts_now;
      chk("R2 loaded value plus latency", ts_now, p + 64'd2);
   endtask

   task automatic next_strobe(output logic [63:0] tag, output logic [31:0] ph);
      tag = 0; ph = 0;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (smp_vld) begin
            tag = smp_ts; ph = nco_phase;
            break;
         end
      end
   endtask

   initial begin
      logic [63:0] s, a, b, l;
      logic [31:0] pa, pb;
      int seen;
      repeat (3) @(negedge clk);
      chk("R1 ts in reset", ts_now, 0);
      chk("R1 strobe in reset", 64'(smp_vld), 0);
      chk("R1 armed in reset", 64'(armed), 0);
      chk("R1 late in reset", 64'(late), 0);
      chk("R1 phase in reset", 64'(nco_phase), 0);
      chk("R1 gap in reset", 64'(trig_gap), 0);
      rst_n = 1;

      seen = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (smp_vld) seen++;
      end
      chk("R6 no strobe before first start", 64'(seen), 0);

      pps_load(64'd1000, l);
      repeat (5) @(negedge clk);
      chk("R2 R3 held level loads once, counter steps", ts_now, 64'd1007);
      pps_in = 0;

      for (int v = 0; v < NV; v++) begin
         int n;
         do_cfg(VEC[v].d, VEC[v].f);
         arm(VEC[v].lead, s);
         n = 0;
         for (int c = 0; c < int'(VEC[v].lead) + 3 * int'(VEC[v].d) + 20 && n < 3; c++) begin
            @(negedge clk);
            if (smp_vld && smp_ts >= s) begin
               chk("R6 strobe tag", smp_ts, s + 64'(n) * 64'(VEC[v].d));
               if (n == 0) begin
                  chk("R7 phase zero after start", 64'(nco_phase), 0);
                  chk("R4 disarmed after firing", 64'(armed), 0);
               end
               if (n == 1) begin
                  chk("R7 phase after one period", 64'(nco_phase),
                      64'(32'(32'(VEC[v].d) * VEC[v].f)));
                  if (VEC[v].d == 16'd2000)
                     chk("R10 ratio 2000 spacing", smp_ts - s, 64'd2000);
               end
               n++;
            end
         end
         chk("R6 three strobes seen", 64'(n), 3);
      end

      // R8: staged config does not act while running
      do_cfg(16'd5, 32'h10);
      next_strobe(a, pa);
      next_strobe(b, pb);
      chk("R8 ratio unchanged before start", b - a, 64'd2000);
      chk("R8 tuning word unchanged before start", 64'(pb - pa), 64'(32'h0010_0000 * 2000));

      // R5: start time in the past, and equal to now
      @(negedge clk); start_val = ts_now - 64'd1; start_wr = 1;
      @(negedge clk); start_wr = 0;
      chk("R5 late for past time", 64'(late), 1);
      chk("R5 not armed for past time", 64'(armed), 0);
      @(negedge clk); start_val = ts_now; start_wr = 1;
      @(negedge clk); start_wr = 0;
      chk("R5 late for current time", 64'(late), 1);
      next_strobe(a, pa);
      next_strobe(b, pb);
      chk("R5 no fire, old spacing kept", b - a, 64'd2000);

      // R8: staged config applied by the next start
      arm(16'd10, s);
      next_strobe(a, pa);
      next_strobe(b, pb);
      chk("R8 staged ratio applied at start", b - a, 64'd5);
      chk("R8 staged tuning word applied", 64'(pb), 64'd80);

      // R9: gap from load to next strobe
      pps_load(64'h1_0000_0000, l);
      next_strobe(a, pa);
      chk("R9 trigger gap", 64'(trig_gap), a - l + 64'd1);
      pps_in = 0;

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule